// File: doc/BRIEF.md
# Decade Johnson Counter with Decoded Outputs

This block is a ten-state counter built on a five-bit twisted-ring (Johnson) register. Its ten one-hot decoded outputs come up in turn, and a carry output completes one period for every ten counts. Two count inputs are sampled by the system clock through two-flop synchronisers. A count is recognised in two cases:

- `cnt_rise` rises while `cnt_hold` is low.
- `cnt_hold` falls while `cnt_rise` is high.

Either input can therefore act as the clock while the other acts as an enable.

A 4-bit `modulus` input turns the block into a divide-by-N counter for N from 2 to 9. The count that would reach state N lands on state 0 instead. Other modulus values leave the counter free-running over all ten states, which gives divide-by-ten on the carry output. Larger sequences are built by chaining stages through the carry output.

An asynchronous master reset puts the counter in state 0 without waiting for a clock edge. A register code outside the ten legal Johnson codes decodes to all-zero and returns to state 0 on the next count.

Top module: `decade_ring_counter`

## Requirements
- R1: While `arst` is high, `dec_out` is 10'b0000000001 and `carry_out` is 1, and this takes effect without any clock edge.
- R2: Exactly one bit of `dec_out` is high, with bit k high in state k. Each count moves from state k to state k+1, and from state 9 to state 0.
- R3: A rising edge of the synchronised `cnt_rise` while the synchronised `cnt_hold` is low advances the state by exactly one.
- R4: A falling edge of the synchronised `cnt_hold` while the synchronised `cnt_rise` is high advances the state by exactly one.
- R5: A rising `cnt_rise` while `cnt_hold` is high, or a falling `cnt_hold` while `cnt_rise` is low, causes no count. When both qualifying edges are seen in the same clock, the state advances by one only.
- R6: An input change made before clock edge 1 shows on `dec_out` after clock edge 3 and not earlier: two synchroniser stages plus the state register.
- R7: `carry_out` is 1 in states 0 to 4 and 0 in states 5 to 9.
- R8: With `modulus` N in 2..9, a count from state N-1 goes to state 0, so the counter cycles through N states.
- R9: With `modulus` equal to 0, 1 or 10..15, the counter free-runs through all ten states.
- R10: If `modulus` is set to N in 2..9 while the state is N or higher, the next count goes to state 0.
- R11: Without a count event the state holds, including when `modulus` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| arst | input | 1 | Asynchronous master reset, active high |
| cnt_rise | input | 1 | Count input that counts on its rising edge while `cnt_hold` is low |
| cnt_hold | input | 1 | Count input that counts on its falling edge while `cnt_rise` is high |
| modulus | input | 4 | Divide ratio; 2..9 selects divide-by-N, any other value free-runs |
| dec_out | output | 10 | One-hot decoded state, bit k high in state k |
| carry_out | output | 1 | High in states 0..4, low in states 5..9 |

## Verification
The bench targets the edge orderings that give no count. A design that qualifies edges on the wrong level of the other input would take an extra count there. A design that adds the two edge terms instead of OR-ing them would step twice on a simultaneous rise-and-fall.

It measures the exact three-edge latency, which catches a missing or extra synchroniser stage. It also drives the wrap at state N-1 for a short modulus, where an off-by-one comparison leaves N+1 states or N-1 states in the cycle.

It lowers the modulus below the current state, which exposes an equality-only wrap because the counter then runs on to state 9. Finally it asserts reset between clock edges to catch a reset that waits for the clock.

// File: rtl/decade_ring_counter.sv
module decade_ring_counter #(
  parameter int STAGES     = 5,
  parameter int SYNC_DEPTH = 2,
  localparam int STATES    = 2 * STAGES,
  localparam int MW        = $clog2(STATES + 1)
) (
  input  logic              clk,
  input  logic              arst,
  input  logic              cnt_rise,
  input  logic              cnt_hold,
  input  logic [MW-1:0]     modulus,
  output logic [STATES-1:0] dec_out,
  output logic              carry_out
);

  logic [SYNC_DEPTH-1:0] rise_pipe, hold_pipe;
  logic                  rise_last, hold_last;
  logic                  rise_now, hold_now;
  logic                  step;
  logic [STAGES-1:0]     ring, shifted, ring_nxt;
  logic [STATES-1:0]     hit;
  logic [MW-1:0]         next_idx;
  logic                  legal, mod_on;

  function automatic logic [STAGES-1:0] jcode(input int k);
    logic [STAGES-1:0] c;
    for (int i = 0; i < STAGES; i++)
      c[i] = (k <= STAGES) ? (i < k) : (i >= k - STAGES);
    return c;
  endfunction

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      rise_pipe <= '0;
      hold_pipe <= '0;
      rise_last <= 1'b0;
      hold_last <= 1'b0;
    end else begin
      rise_pipe <= {rise_pipe[SYNC_DEPTH-2:0], cnt_rise};
      hold_pipe <= {hold_pipe[SYNC_DEPTH-2:0], cnt_hold};
      rise_last <= rise_now;
      hold_last <= hold_now;
    end
  end

  assign rise_now = rise_pipe[SYNC_DEPTH-1];
  assign hold_now = hold_pipe[SYNC_DEPTH-1];
  assign step = (rise_now & ~rise_last & ~hold_now) |
                (hold_last & ~hold_now & rise_now);

  genvar g;
  generate
    for (g = 0; g < STATES; g++) begin : g_dec
      assign hit[g] = (ring == jcode(g));
    end
  endgenerate

  assign legal   = |hit;
  assign shifted = {ring[STAGES-2:0], ~ring[STAGES-1]};
  assign mod_on  = (modulus >= MW'(2)) && (modulus < MW'(STATES));

  always_comb begin
    next_idx = '0;
    for (int k = 0; k < STATES; k++)
      if (shifted == jcode(k)) next_idx = MW'(k);
  end

  always_comb begin
    ring_nxt = shifted;
    if (!legal) ring_nxt = '0;
    else if (mod_on && next_idx >= modulus) ring_nxt = '0;
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) ring <= '0;
    else if (step) ring <= ring_nxt;
  end

  assign dec_out   = hit;
  assign carry_out = ~ring[STAGES-1];

endmodule

// File: rtl/decade_ring_chk.sv
module decade_ring_chk #(
  parameter int STATES = 10,
  parameter int MW     = 4
) (
  input logic              clk,
  input logic              arst,
  input logic              step,
  input logic [MW-1:0]     modulus,
  input logic [STATES-1:0] dec_out,
  input logic              carry_out
);

  logic mod_on;
  assign mod_on = (modulus >= MW'(2)) && (modulus < MW'(STATES));

  // R2
  one_hot_chk: assert property (@(posedge clk) disable iff (arst)
    $countones(dec_out) == 1);

  // R7
  carry_half_chk: assert property (@(posedge clk) disable iff (arst)
    carry_out == (|dec_out[STATES/2-1:0]));

  // R11
  hold_still_chk: assert property (@(posedge clk) disable iff (arst)
    !step |=> $stable(dec_out));

  // R2
  advance_chk: assert property (@(posedge clk) disable iff (arst)
    (step && !mod_on && !dec_out[STATES-1]) |=> dec_out == ($past(dec_out) << 1));

  // R2
  wrap_top_chk: assert property (@(posedge clk) disable iff (arst)
    (step && dec_out[STATES-1]) |=> dec_out[0]);

  // R8
  wrap_mod_chk: assert property (@(posedge clk) disable iff (arst)
    (step && mod_on && dec_out[modulus - MW'(1)]) |=> dec_out[0]);

endmodule

bind decade_ring_counter decade_ring_chk #(.STATES(STATES), .MW(MW)) u_chk (
  .clk(clk), .arst(arst), .step(step), .modulus(modulus),
  .dec_out(dec_out), .carry_out(carry_out)
);

// File: tb/tb_decade_ring_counter.sv
module tb_decade_ring_counter;
  logic       clk = 1'b0;
  logic       arst = 1'b1;
  logic       cnt_rise = 1'b0;
  logic       cnt_hold = 1'b0;
  logic [3:0] modulus = 4'd0;
  logic [9:0] dec_out;
  logic       carry_out;

  int vectors = 0;
  int misses  = 0;

  int m_idx = 0;
  bit ra1, ra2, ra3, hb1, hb2, hb3;

  decade_ring_counter dut (
    .clk(clk), .arst(arst), .cnt_rise(cnt_rise), .cnt_hold(cnt_hold),
    .modulus(modulus), .dec_out(dec_out), .carry_out(carry_out)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (arst) begin
      m_idx = 0;
      {ra1, ra2, ra3, hb1, hb2, hb3} = '0;
    end else begin
      if ((ra2 && !ra3 && !hb2) || (hb3 && !hb2 && ra2)) begin
        int n;
        n = (m_idx + 1) % 10;
        if (modulus >= 2 && modulus <= 9 && n >= modulus) n = 0;
        m_idx = n;
      end
      ra3 = ra2; ra2 = ra1; ra1 = cnt_rise;
      hb3 = hb2; hb2 = hb1; hb1 = cnt_hold;
    end
    chk(dec_out == (10'd1 << m_idx), "R2 model dec_out", dec_out, 10'd1 << m_idx);
    chk(carry_out == (m_idx < 5), "R7 model carry_out", carry_out, m_idx < 5);
  end

  task automatic drive(input bit a, input bit b, input int wait_cycles);
    @(negedge clk);
    #5;
    cnt_rise = a;
    cnt_hold = b;
    repeat (wait_cycles) @(negedge clk);
  endtask

  task automatic set_mod(input int m);
    @(negedge clk);
    #5;
    modulus = 4'(m);
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_rise(input int n);
    for (int i = 0; i < n; i++) begin
      drive(1'b1, 1'b0, 4);
      drive(1'b0, 1'b0, 4);
    end
  endtask

  task automatic pulse_fall(input int n);
    for (int i = 0; i < n; i++) begin
      drive(1'b0, 1'b1, 4);
      drive(1'b1, 1'b1, 4);
      drive(1'b1, 1'b0, 4);
      drive(1'b0, 1'b0, 4);
    end
  endtask

  task automatic expect_state(input int idx, input string tag);
    #1;
    chk(dec_out == (10'd1 << idx), tag, dec_out, 10'd1 << idx);
  endtask

  initial begin
    #1;
    chk(dec_out == 10'd1, "R1 reset dec_out", dec_out, 1);
    chk(carry_out == 1'b1, "R1 reset carry_out", carry_out, 1);
    repeat (3) @(negedge clk);
    #5 arst = 1'b0;
    repeat (2) @(negedge clk);

    pulse_rise(3);
    expect_state(3, "R3 three rising counts");

    drive(1'b1, 1'b0, 0);
    @(negedge clk);
    @(negedge clk);
    expect_state(3, "R6 no change after second edge");
    @(negedge clk);
    expect_state(4, "R6 change after third edge");
    drive(1'b0, 1'b0, 4);

    pulse_fall(2);
    expect_state(6, "R4 two falling counts");
    #1 chk(carry_out == 1'b0, "R7 carry low in state 6", carry_out, 0);

    drive(1'b0, 1'b1, 4);
    drive(1'b0, 1'b0, 4);
    expect_state(6, "R5 fall while rise input low");
    drive(1'b0, 1'b1, 4);
    drive(1'b1, 1'b0, 4);
    expect_state(7, "R5 simultaneous edges count once");
    drive(1'b0, 1'b0, 4);
    drive(1'b0, 1'b1, 4);
    drive(1'b1, 1'b1, 4);
    expect_state(7, "R5 rise while hold input high");
    drive(1'b0, 1'b0, 4);

    pulse_rise(2);
    expect_state(9, "R2 state nine");
    pulse_rise(1);
    expect_state(0, "R2 wrap nine to zero");

    set_mod(4);
    expect_state(0, "R11 modulus change holds");
    pulse_rise(3);
    expect_state(3, "R8 state three under modulus four");
    pulse_rise(1);
    expect_state(0, "R8 wrap at modulus four");
    pulse_rise(2);
    expect_state(2, "R8 second cycle");

    set_mod(0);
    pulse_rise(5);
    expect_state(7, "R9 free run past four");
    set_mod(3);
    expect_state(7, "R11 lowered modulus holds");
    pulse_rise(1);
    expect_state(0, "R10 beyond modulus to zero");

    set_mod(1);
    pulse_rise(9);
    expect_state(9, "R9 modulus one reaches nine");
    set_mod(12);
    pulse_rise(1);
    expect_state(0, "R9 modulus twelve wraps at ten");
    pulse_rise(6);

    @(negedge clk);
    #5 arst = 1'b1;
    #1;
    chk(dec_out == 10'd1, "R1 async reset mid cycle", dec_out, 1);
    chk(carry_out == 1'b1, "R1 async reset carry", carry_out, 1);
    repeat (2) @(negedge clk);
    #5 arst = 1'b0;
    pulse_rise(1);
    expect_state(1, "R3 count after reset");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #4000000;
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule